// File: doc/BRIEF.md
# Split-Read Truncated-Frame Error Counter

This block counts transmit frames that were cut short because a FIFO underflow persisted. Each cycle with the increment input high adds one to a 36-bit count. The count stops at all ones and does not wrap.

The count is read over a 32-bit register bus as two adjacent word addresses. The base address returns the low 32 bits. The next address returns the top 4 bits, zero-extended. Reading the upper word clears the count, so software reads the lower word first and the upper word second.

When the lower word is read, the upper bits are captured in a shadow register. The next upper-word read returns the shadow, so the two halves belong to the same snapshot. The register is read-only: write strobes are accepted and ignored.

Top module: `err_cnt_split_rd`

## Requirements
- R1: After reset the count is zero, and reads of both words return zero.
- R2: A read strobe, with no write strobe, returns data and raises `rd_valid_o` on the cycle after the strobe. At the base address the data is count bits 31:0, as they were on the strobe cycle.
- R3: A read at base+1 returns the upper count bits in bits 3:0 of the word, and bits 31:4 read as zero.
- R4: A read at base+1 clears the count to zero.
- R5: A read at the base address leaves the count unchanged.
- R6: A write strobe to either address, or a strobe that has read and write high together, has no effect on the count or the shadow and returns no data.
- R7: An increment in the same cycle as a clearing read leaves the count at 1.
- R8: The count saturates at all ones. Increments there keep it at all ones.
- R9: A lower-word read captures the upper count bits into a shadow register. The next upper-word read returns the shadow, even if the count has changed in between.
- R10: An upper-word read with no lower-word read since the last upper-word read (or since reset) returns the live upper bits.
- R11: A read at any other address returns zero and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| incr_i | input | 1 | One truncated frame seen this cycle |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored) |
| addr_i | input | ADDR_W (8) | Word address |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | BUS_W (32) | Read data |

## Verification
All read data is registered once. A strobe at a negative edge therefore produces its data at the next positive edge, and the bench samples it at the following negative edge.

The count changes at the same positive edge as the strobe or increment that caused it. The bench never reads the count directly; it observes the count only through a later lower-word read, after one more register stage.

Saturation and the shadow ordering need the upper bits to move. These are run on a second instance with a 4-bit bus and a 6-bit count. All expected words are computed from the requirements, one task per scenario.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/err_cnt_core.sv
module err_cnt_core #(
  parameter int CNT_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             incr_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= incr_i ? CNT_ONE : '0;  // event kept
    else if (incr_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/err_cnt_regif.sv
module err_cnt_regif
  import err_cnt_pkg::*;
#(
  parameter int                CNT_W     = 36,
  parameter int                BUS_W     = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic              rd_valid_o,
  output logic [BUS_W-1:0]  rd_data_o
);
  localparam int                HI_W    = CNT_W - BUS_W;
  localparam int                PAD_W   = BUS_W - HI_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

  rd_sel_e           sel;
  logic              rd_ok;
  logic [HI_W-1:0]   shadow_q;
  logic              shadow_vld_q;
  logic [HI_W-1:0]   hi_val;
  logic [BUS_W-1:0]  data_d;

  // a write strobe owns the bus cycle, so a collided read is dropped
  assign rd_ok = rd_en_i && !wr_en_i;

  always_comb begin
    sel = SEL_NONE;
    if (rd_ok && addr_i == BASE_ADDR)    sel = SEL_LO;
    else if (rd_ok && addr_i == HI_ADDR) sel = SEL_HI;
  end

  assign clr_o  = (sel == SEL_HI);
  assign hi_val = shadow_vld_q ? shadow_q : cnt_i[CNT_W-1:BUS_W];

  always_comb begin
    unique case (sel)
      SEL_LO:  data_d = cnt_i[BUS_W-1:0];
      SEL_HI:  data_d = {{PAD_W{1'b0}}, hi_val};
      default: data_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q     <= '0;
      shadow_vld_q <= 1'b0;
    end else if (sel == SEL_LO) begin
      shadow_q     <= cnt_i[CNT_W-1:BUS_W];
      shadow_vld_q <= 1'b1;
    end else if (sel == SEL_HI) begin
      shadow_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_ok;
      rd_data_o  <= data_d;
    end
  end
endmodule

// File: rtl/err_cnt_split_rd.sv
module err_cnt_split_rd #(
  parameter int                CNT_W     = 36,
  parameter int                BUS_W     = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              incr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_valid_o,
  output logic [BUS_W-1:0]  rd_data_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  err_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .incr_i (incr_i),
    .clr_i  (clr),
    .cnt_o  (cnt_q)
  );

  err_cnt_regif #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .cnt_i      (cnt_q),
    .clr_o      (clr),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/err_cnt_split_rd_sva.sv
module err_cnt_split_rd_sva #(
  parameter int                CNT_W     = 36,
  parameter int                BUS_W     = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              incr_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_valid_o,
  input logic [BUS_W-1:0]  rd_data_o,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam int                HI_W    = CNT_W - BUS_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic rd_lo, rd_hi;
  assign rd_lo = rd_en_i && !wr_en_i && addr_i == BASE_ADDR;
  assign rd_hi = rd_en_i && !wr_en_i && addr_i == HI_ADDR;

  assert_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> rd_valid_o);
  assert_no_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> !rd_valid_o);
  assert_lo_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> rd_data_o == $past(cnt_i[BUS_W-1:0]));
  assert_hi_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |=> rd_data_o[BUS_W-1:HI_W] == '0);
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && !incr_i) |=> cnt_i == '0);
  assert_lo_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && !incr_i) |=> $stable(cnt_i));
  assert_idle_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!incr_i && !rd_hi) |=> $stable(cnt_i));
  assert_clr_incr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && incr_i) |=> cnt_i == CNT_W'(1));
  assert_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !rd_hi) |=> cnt_i == CNT_MAX);
endmodule

bind err_cnt_split_rd err_cnt_split_rd_sva #(
  .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .incr_i     (incr_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .cnt_i      (cnt_q)
);

// File: tb/err_cnt_split_rd_tb.sv
module err_cnt_split_rd_tb;
  localparam logic [7:0] BASE = 8'h30;
  localparam logic [7:0] HI   = 8'h31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        incr = 0, rd_en = 0, wr_en = 0;
  logic [7:0]  addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  logic        s_incr = 0, s_rd_en = 0;
  logic [7:0]  s_addr = '0;
  logic        s_rd_valid;
  logic [3:0]  s_rd_data;

  int n_chk = 0;
  int n_err = 0;

  err_cnt_split_rd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .incr_i(incr), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // narrow variant so saturation and upper-bit motion are reachable
  err_cnt_split_rd #(.CNT_W(6), .BUS_W(4)) u_sat (
    .clk_i(clk), .rst_ni(rst_n), .incr_i(s_incr), .rd_en_i(s_rd_en),
    .wr_en_i(1'b0), .addr_i(s_addr), .rd_valid_o(s_rd_valid), .rd_data_o(s_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bump(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); incr = 1'b1;
    end
    @(negedge clk); incr = 1'b0;
  endtask

  task automatic s_bump(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_incr = 1'b1;
    end
    @(negedge clk); s_incr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic with_incr, output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; addr = a; incr = with_incr;
    @(negedge clk); rd_en = 1'b0; incr = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic s_rd(input logic [7:0] a, output logic [3:0] d);
    @(negedge clk); s_rd_en = 1'b1; s_addr = a;
    @(negedge clk); s_rd_en = 1'b0;
    d = s_rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    check("R1 data after reset", rd_data, 32'h0);
    check("R1 valid after reset", {31'b0, rd_valid}, 32'h0);
    rd(BASE, 0, d, v); check("R1 low word", d, 0);
    rd(HI,   0, d, v); check("R1 upper word", d, 0);
  endtask

  task automatic t_lo_hi_clear;
    logic [31:0] d; logic v;
    bump(5);
    rd(BASE, 0, d, v); check("R2 low word", d, 5); check("R2 valid", {31'b0, v}, 1);
    rd(BASE, 0, d, v); check("R5 low read keeps count", d, 5);
    rd(HI,   0, d, v); check("R3 upper word padded", d, 0);
    rd(BASE, 0, d, v); check("R4 cleared by upper read", d, 0);
    rd(HI,   0, d, v);
  endtask

  task automatic t_writes;
    logic [31:0] d; logic v;
    bump(2);
    @(negedge clk); wr_en = 1'b1; addr = HI;
    @(negedge clk); addr = BASE;
    @(negedge clk); rd_en = 1'b1; addr = HI;   // collided strobe
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R6 no valid on write", {31'b0, rd_valid}, 0);
    rd(BASE, 0, d, v); check("R6 writes leave count", d, 2);
    rd(8'h32, 0, d, v); check("R11 other address reads zero", d, 0);
    rd(BASE, 0, d, v); check("R11 other address keeps count", d, 2);
    rd(HI, 0, d, v);
  endtask

  task automatic t_clr_incr;
    logic [31:0] d; logic v;
    bump(4);
    rd(HI, 1, d, v); check("R7 upper word before clear", d, 0);
    rd(BASE, 0, d, v); check("R7 coincident increment kept", d, 1);
    rd(HI, 0, d, v);
    rd(BASE, 0, d, v); check("R4 cleared again", d, 0);
    rd(HI, 0, d, v);
  endtask

  task automatic t_saturate;
    logic [3:0] d;
    s_bump(70);
    s_rd(BASE, d); check("R8 low bits at max", {28'b0, d}, 4'hF);
    s_rd(HI,   d); check("R8 upper bits at max", {28'b0, d}, 4'h3);
    s_rd(BASE, d); check("R8 cleared after upper read", {28'b0, d}, 0);
    s_rd(HI,   d);
  endtask

  task automatic t_shadow;
    logic [3:0] d;
    s_bump(15);
    s_rd(BASE, d); check("R9 low snapshot", {28'b0, d}, 4'hF);
    s_bump(1);     // upper bits move to 1
    s_rd(HI,   d); check("R9 shadow returned", {28'b0, d}, 0);
    s_rd(HI,   d); check("R10 live after clear", {28'b0, d}, 0);
    s_bump(20);
    s_rd(HI,   d); check("R10 live upper bits", {28'b0, d}, 4'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lo_hi_clear();
    t_writes();
    t_clr_incr();
    t_saturate();
    t_shadow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule